// File: doc/BRIEF.md
# Idle Cell Screening Filter

This block sits on the receive side of an ATM cell path and removes unwanted cells before they reach any output port. Bytes arrive one per clock, with a start-of-cell flag on the first byte of each 53-byte cell. The block compares the 4-byte cell header against a programmable idle pattern under a programmable bit mask. Independently, it compares the header against a reject pattern held for each port. A cell is discarded when screening is enabled and the idle compare hits, or when the addressed port's reject compare is enabled and hits. HEC bytes, HEC checking and cell delineation are handled elsewhere.

The keep or drop decision is made for the whole cell once its fourth header byte has arrived. A short delay line holds the first header bytes until then, so a discarded cell produces no output bytes at all. A cell that is kept comes out unchanged, with its start-of-cell flag. The strobe of the port selected for that cell marks every one of its bytes. All configuration inputs are sampled once per cell, at its start-of-cell byte.

Top module: `idle_cell_screen`

## Requirements
- R1: Every byte of a kept cell appears on `outByte` with `outValid` high on the fourth rising clock edge after the edge that accepts it, in order. `outSoc` is high on its first byte. Cycles with `inValid` low inside the payload produce no output byte.
- R2: The header word is the first four bytes of a cell, with the first byte in bits 31:24. A mask bit of 1 compares the header bit and a mask bit of 0 ignores it. When `dropIdleEn` is 1 and the masked header equals `idleHdr`, no byte of the cell is output.
- R3: When `dropIdleEn` is 0, a header matching the idle pattern is passed like any other cell.
- R4: Port p uses bits [32p+31:32p] of `rejHdr` and `rejMask`. When `rejEn[p]` is 1 for the addressed port and the masked header matches, the cell is dropped. A cell is dropped if either the idle test or the reject test hits.
- R5: The reject patterns and enables of ports other than the addressed one have no effect on the cell.
- R6: Bit `portSel` of `outPortStrobe` is high on exactly the cycles where `outValid` is high, and all other strobe bits stay low.
- R7: `portSel`, `dropIdleEn`, `idleHdr`, `idleMask`, `rejEn`, `rejHdr` and `rejMask` are sampled on the cycle of the start-of-cell byte. Later changes within the same cell do not affect its decision or its strobe.
- R8: Every start-of-cell resynchronises the block. A cell whose start byte is not followed by three valid non-start bytes on consecutive cycles is dropped whole. Bytes after the 53rd without a new start are not output. Bytes received before the first start after reset are not output.
- R9: While `rstN` is low, `outValid` and `outPortStrobe` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input byte is present |
| inSoc | input | 1 | Input byte is the first byte of a cell |
| inByte | input | 8 | Input cell byte |
| portSel | input | 2 | Port addressed by the cell |
| dropIdleEn | input | 1 | Enable idle cell removal |
| idleHdr | input | 32 | Idle header pattern |
| idleMask | input | 32 | Idle compare mask, 1 = compare |
| rejEn | input | 4 | Per-port reject enable |
| rejHdr | input | 128 | Per-port reject patterns, 32 bits each |
| rejMask | input | 128 | Per-port reject masks, 32 bits each |
| outValid | output | 1 | Output byte is present |
| outSoc | output | 1 | Output byte is the first byte of a cell |
| outByte | output | 8 | Output cell byte |
| outPortStrobe | output | 4 | Per-port byte strobe, only the addressed port active |

## Verification
Every output byte is due on the fourth rising edge after the edge that accepts its input byte. This holds for kept cells and for the silence of dropped ones. When the bench drives a byte, it writes the expected output into a small ring slot that lies four edges ahead of the current edge. On every falling edge it compares the outputs with the slot for that edge, so each cycle is checked exactly where the result is due. Cells are decided at their fourth header byte, so a dropped cell and a kept cell sent back to back are checked at the boundary where the verdict switches.

// File: rtl/idle_screen_pkg.sv
package idle_screen_pkg;
  localparam int unsigned BYTE_W = 8;

  // one delay-line slot: a byte with its qualifiers
  typedef struct packed {
    logic              valid;
    logic              soc;
    logic [BYTE_W-1:0] data;
  } lane_t;

  // strobes from control to datapath
  typedef struct packed {
    logic keepLoad;  // start byte of a cell moves to the output slot
    logic keepVal;   // verdict for that cell: 1 = pass
  } verdict_t;
endpackage

// File: rtl/idle_screen_ctl.sv
module idle_screen_ctl
  import idle_screen_pkg::*;
#(
  parameter int unsigned NPORTS    = 4,
  parameter int unsigned HDR_BYTES = 4,
  parameter int unsigned PORT_W    = $clog2(NPORTS)
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             inValid,
  input  logic                             inSoc,
  input  logic [BYTE_W-1:0]                inByte,
  input  logic [PORT_W-1:0]                portSel,
  input  logic                             dropIdleEn,
  input  logic [HDR_BYTES*BYTE_W-1:0]      idleHdr,
  input  logic [HDR_BYTES*BYTE_W-1:0]      idleMask,
  input  logic [NPORTS-1:0]                rejEn,
  input  logic [NPORTS*HDR_BYTES*BYTE_W-1:0] rejHdr,
  input  logic [NPORTS*HDR_BYTES*BYTE_W-1:0] rejMask,
  input  lane_t [HDR_BYTES-2:0]            lanes,
  output verdict_t                         verdict,
  output logic [PORT_W-1:0]                cellPort
);
  localparam int unsigned HDR_W = HDR_BYTES * BYTE_W;
  localparam int unsigned OLD   = HDR_BYTES - 2;  // slot holding header byte 0

  logic [HDR_W-1:0]  shIdleHdr, shIdleMask, shRejHdr, shRejMask;
  logic              shIdleEn, shRejEn;
  logic [PORT_W-1:0] shPort;
  logic              cellStart;
  logic [HDR_W-1:0]  hdrWord;
  logic              hdrOk, idleHit, rejHit;

  assign cellStart = inValid && inSoc;

  // per-cell shadow copy; only the addressed port's reject entry is kept
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shIdleHdr  <= '0;
      shIdleMask <= '0;
      shIdleEn   <= 1'b0;
      shRejHdr   <= '0;
      shRejMask  <= '0;
      shRejEn    <= 1'b0;
      shPort     <= '0;
    end else if (cellStart) begin
      shIdleHdr  <= idleHdr;
      shIdleMask <= idleMask;
      shIdleEn   <= dropIdleEn;
      shRejHdr   <= rejHdr[int'(portSel)*HDR_W +: HDR_W];
      shRejMask  <= rejMask[int'(portSel)*HDR_W +: HDR_W];
      shRejEn    <= rejEn[portSel];
      shPort     <= portSel;
    end
  end

  // header assembled from the delay line plus the byte now arriving
  always_comb begin
    hdrWord              = '0;
    hdrWord[BYTE_W-1:0]  = inByte;
    hdrOk = inValid && !inSoc && lanes[OLD].valid && lanes[OLD].soc;
    for (int i = 0; i < HDR_BYTES - 1; i++) begin
      hdrWord[BYTE_W*(i+1) +: BYTE_W] = lanes[i].data;
      if (i < OLD) hdrOk = hdrOk && lanes[i].valid && !lanes[i].soc;
    end
  end

  assign idleHit = shIdleEn && (((hdrWord ^ shIdleHdr) & shIdleMask) == '0);
  assign rejHit  = shRejEn  && (((hdrWord ^ shRejHdr)  & shRejMask)  == '0);

  assign verdict.keepLoad = lanes[OLD].valid && lanes[OLD].soc;
  assign verdict.keepVal  = hdrOk && !idleHit && !rejHit;
  assign cellPort         = shPort;

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cellStart) |-> ($stable(shIdleHdr) && $stable(shIdleEn) && $stable(shPort)))
    else $error("config shadow moved inside a cell"); // R7
endmodule

// File: rtl/idle_screen_dp.sv
module idle_screen_dp
  import idle_screen_pkg::*;
#(
  parameter int unsigned NPORTS     = 4,
  parameter int unsigned HDR_BYTES  = 4,
  parameter int unsigned CELL_BYTES = 53,
  parameter int unsigned PORT_W     = $clog2(NPORTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic                 inSoc,
  input  logic [BYTE_W-1:0]    inByte,
  input  verdict_t             verdict,
  input  logic [PORT_W-1:0]    cellPort,
  output lane_t [HDR_BYTES-2:0] lanes,
  output logic                 outValid,
  output logic                 outSoc,
  output logic [BYTE_W-1:0]    outByte,
  output logic [NPORTS-1:0]    outPortStrobe
);
  localparam int unsigned IDX_W = $clog2(CELL_BYTES + 1);
  localparam int unsigned LAST  = HDR_BYTES - 1;

  lane_t [HDR_BYTES-1:0] stage;
  lane_t                 newLane;
  logic                  keepReg;
  logic [PORT_W-1:0]     portReg;
  logic [IDX_W-1:0]      idx;   // position of the byte in the output slot

  assign newLane = '{valid: inValid, soc: inValid && inSoc, data: inByte};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage <= '0;
    else       stage <= {stage[HDR_BYTES-2:0], newLane};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keepReg <= 1'b0;
      portReg <= '0;
      idx     <= IDX_W'(CELL_BYTES);
    end else begin
      if (verdict.keepLoad) begin
        keepReg <= verdict.keepVal;
        portReg <= cellPort;
      end
      if (stage[LAST-1].valid) begin
        if (stage[LAST-1].soc)                idx <= '0;
        else if (idx != IDX_W'(CELL_BYTES))   idx <= idx + 1'b1;
      end
    end
  end

  assign lanes    = stage[HDR_BYTES-2:0];
  assign outValid = stage[LAST].valid && keepReg && (idx < IDX_W'(CELL_BYTES));
  assign outSoc   = outValid && stage[LAST].soc;
  assign outByte  = stage[LAST].data;

  for (genvar p = 0; p < NPORTS; p++) begin : g_strobe
    assign outPortStrobe[p] = outValid && (portReg == PORT_W'(p));
  end

  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (verdict.keepLoad && !verdict.keepVal) |=> !outValid)
    else $error("dropped cell produced a byte"); // R2
  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(outPortStrobe))
    else $error("more than one port strobe"); // R6
  AST_STROBE_WITH_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ($countones(outPortStrobe) == 1))
    else $error("byte without port strobe"); // R6
endmodule

// File: rtl/idle_cell_screen.sv
module idle_cell_screen
  import idle_screen_pkg::*;
#(
  parameter int unsigned NPORTS     = 4,
  parameter int unsigned HDR_BYTES  = 4,
  parameter int unsigned CELL_BYTES = 53
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               inValid,
  input  logic                               inSoc,
  input  logic [7:0]                         inByte,
  input  logic [$clog2(NPORTS)-1:0]          portSel,
  input  logic                               dropIdleEn,
  input  logic [HDR_BYTES*8-1:0]             idleHdr,
  input  logic [HDR_BYTES*8-1:0]             idleMask,
  input  logic [NPORTS-1:0]                  rejEn,
  input  logic [NPORTS*HDR_BYTES*8-1:0]      rejHdr,
  input  logic [NPORTS*HDR_BYTES*8-1:0]      rejMask,
  output logic                               outValid,
  output logic                               outSoc,
  output logic [7:0]                         outByte,
  output logic [NPORTS-1:0]                  outPortStrobe
);
  localparam int unsigned PORT_W = $clog2(NPORTS);

  verdict_t              verdict;
  logic [PORT_W-1:0]     cellPort;
  lane_t [HDR_BYTES-2:0] lanes;

  idle_screen_ctl #(.NPORTS(NPORTS), .HDR_BYTES(HDR_BYTES), .PORT_W(PORT_W)) u_ctl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSoc(inSoc), .inByte(inByte),
    .portSel(portSel), .dropIdleEn(dropIdleEn), .idleHdr(idleHdr), .idleMask(idleMask),
    .rejEn(rejEn), .rejHdr(rejHdr), .rejMask(rejMask), .lanes(lanes),
    .verdict(verdict), .cellPort(cellPort)
  );

  idle_screen_dp #(.NPORTS(NPORTS), .HDR_BYTES(HDR_BYTES), .CELL_BYTES(CELL_BYTES),
                   .PORT_W(PORT_W)) u_dp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSoc(inSoc), .inByte(inByte),
    .verdict(verdict), .cellPort(cellPort), .lanes(lanes),
    .outValid(outValid), .outSoc(outSoc), .outByte(outByte), .outPortStrobe(outPortStrobe)
  );
endmodule

// File: tb/tb_idle_cell_screen.sv
`timescale 1ns/1ps
module tb_idle_cell_screen;
  logic         clk = 1'b0;
  logic         rstN;
  logic         inValid, inSoc;
  logic [7:0]   inByte;
  logic [1:0]   portSel;
  logic         dropIdleEn;
  logic [31:0]  idleHdr, idleMask;
  logic [3:0]   rejEn;
  logic [127:0] rejHdr, rejMask;
  logic         outValid, outSoc;
  logic [7:0]   outByte;
  logic [3:0]   outPortStrobe;

  always #4 clk = ~clk;  // 125 MHz

  idle_cell_screen dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSoc(inSoc), .inByte(inByte),
    .portSel(portSel), .dropIdleEn(dropIdleEn), .idleHdr(idleHdr), .idleMask(idleMask),
    .rejEn(rejEn), .rejHdr(rejHdr), .rejMask(rejMask),
    .outValid(outValid), .outSoc(outSoc), .outByte(outByte), .outPortStrobe(outPortStrobe)
  );

  typedef struct packed {
    logic [31:0] hdr;
    logic        idleOn;
    logic [3:0]  rej;
    logic [1:0]  port;
    logic        keep;
  } vec_t;

  // idle 00000001 / mask FFFFFFF1; port1 reject 12345670/FFFFFFF0; port2 ABCD0000/FFFF0000
  localparam vec_t VECS [10] = '{
    '{32'h0000_0001, 1'b1, 4'b0000, 2'd0, 1'b0},  // R2 exact idle
    '{32'h0000_000F, 1'b1, 4'b0000, 2'd0, 1'b0},  // R2 masked bits ignored
    '{32'h0000_0011, 1'b1, 4'b0000, 2'd1, 1'b1},  // R2 compared bit differs
    '{32'h0000_0001, 1'b0, 4'b0000, 2'd0, 1'b1},  // R3 screening off
    '{32'h1234_567A, 1'b1, 4'b0010, 2'd1, 1'b0},  // R4 reject hit
    '{32'h1234_567A, 1'b1, 4'b0010, 2'd0, 1'b1},  // R5 other port's reject
    '{32'h1234_567A, 1'b1, 4'b0000, 2'd1, 1'b1},  // R4 reject disabled
    '{32'hABCD_1234, 1'b1, 4'b0100, 2'd2, 1'b0},  // R4 port2 reject
    '{32'hABCD_1234, 1'b1, 4'b0100, 2'd3, 1'b1},  // R6 strobe bit 3
    '{32'h0000_0001, 1'b1, 4'b0010, 2'd1, 1'b0}   // R4 idle alone suffices
  };
  localparam string VREQ [10] = '{"R2", "R2", "R2", "R3", "R4", "R5", "R4", "R4", "R6", "R4"};

  int    cyc = 0;
  int    nChecks = 0;
  int    nBad = 0;
  logic  checking = 1'b0;
  logic  finished = 1'b0;
  int    slotNow;
  logic  [3:0] expStb;
  logic  expV [8];
  logic  expS [8];
  logic  [7:0] expB [8];
  logic  [1:0] expP [8];
  string expR [8];

  always @(posedge clk) cyc <= cyc + 1;

  // present one input byte and book its expected output four edges ahead (R1)
  task automatic drive(input logic v, input logic s, input logic [7:0] d,
                       input logic k, input logic [1:0] p, input string req);
    int sl;
    @(posedge clk); #1;
    inValid = v; inSoc = s; inByte = d;
    sl = (cyc + 4) % 8;
    expV[sl] = v && k; expS[sl] = s; expB[sl] = d; expP[sl] = p; expR[sl] = req;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 8'h00, 1'b0, 2'd0, "R1");
  endtask

  task automatic sendCell(input logic [31:0] hdr, input int len, input logic keep,
                          input logic [1:0] port, input string req,
                          input int gapAfter, input int flipAt);
    for (int i = 0; i < len; i++) begin
      logic [7:0] d;
      if (i == flipAt) begin
        dropIdleEn = !dropIdleEn;
        portSel    = portSel + 2'd1;
      end
      d = (i < 4) ? hdr[31-8*i -: 8] : 8'(i * 3 + 8'h5A);
      drive(1'b1, i == 0, d, keep && (i < 53), port, req);
      if (i == gapAfter) drive(1'b0, 1'b0, 8'h00, 1'b0, port, req);
    end
  endtask

  always @(negedge clk) begin
    if (checking && !finished) begin
      slotNow = cyc % 8;
      expStb  = expV[slotNow] ? (4'b0001 << expP[slotNow]) : 4'b0000;
      nChecks++;
      if (outValid !== expV[slotNow] || outPortStrobe !== expStb ||
          (expV[slotNow] && (outByte !== expB[slotNow] || outSoc !== expS[slotNow]))) begin
        nBad++;
        $display("FAIL %s cyc=%0d actual v=%b soc=%b byte=%h stb=%b expected v=%b soc=%b byte=%h stb=%b",
                 expR[slotNow], cyc, outValid, outSoc, outByte, outPortStrobe,
                 expV[slotNow], expS[slotNow], expB[slotNow], expStb);
      end
      expV[slotNow] = 1'b0;
      expR[slotNow] = "R1";
    end
  end

  always @(posedge clk) begin
    if (cyc == 20000 && !finished) begin
      nChecks++;
      nBad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      expV[i] = 1'b0; expS[i] = 1'b0; expB[i] = 8'h00; expP[i] = 2'd0; expR[i] = "R1";
    end
    rstN = 1'b0; inValid = 1'b0; inSoc = 1'b0; inByte = 8'h00; portSel = 2'd0;
    dropIdleEn = 1'b1;
    idleHdr  = 32'h0000_0001;
    idleMask = 32'hFFFF_FFF1;
    rejEn    = 4'b0000;
    rejHdr   = {32'h0000_0000, 32'hABCD_0000, 32'h1234_5670, 32'h0000_0000};
    rejMask  = {32'hFFFF_FFFF, 32'hFFFF_0000, 32'hFFFF_FFF0, 32'hFFFF_FFFF};

    // R9: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    nChecks++;
    if (outValid !== 1'b0) begin
      nBad++; $display("FAIL R9 outValid actual=%b expected=0", outValid);
    end
    nChecks++;
    if (outPortStrobe !== 4'b0000) begin
      nBad++; $display("FAIL R9 strobe actual=%b expected=0000", outPortStrobe);
    end
    @(posedge clk); #1;
    rstN = 1'b1;
    checking = 1'b1;

    // R8: bytes before any start-of-cell are discarded
    for (int i = 0; i < 6; i++) drive(1'b1, 1'b0, 8'(8'h30 + i), 1'b0, 2'd0, "R8");

    // table of cells sent back to back
    for (int v = 0; v < 10; v++) begin
      dropIdleEn = VECS[v].idleOn;
      rejEn      = VECS[v].rej;
      portSel    = VECS[v].port;
      sendCell(VECS[v].hdr, 53, VECS[v].keep, VECS[v].port, VREQ[v], -1, -1);
    end
    idle(2);

    // R7: idle enable and port change mid-cell do not touch this cell
    dropIdleEn = 1'b0; rejEn = 4'b0000; portSel = 2'd2;
    sendCell(32'h0000_0001, 53, 1'b1, 2'd2, "R7", -1, 2);
    dropIdleEn = 1'b1; portSel = 2'd0;

    // R1: payload gap keeps order and gives no byte in the gap cycle
    sendCell(32'h0000_0011, 53, 1'b1, 2'd0, "R1", 10, -1);

    // R8: gap inside the header drops the cell
    sendCell(32'h0000_0011, 53, 1'b0, 2'd0, "R8", 1, -1);

    // R8: truncated cell dropped, following cell kept
    sendCell(32'h0000_0022, 3, 1'b0, 2'd0, "R8", -1, -1);
    sendCell(32'h0000_0033, 53, 1'b1, 2'd0, "R8", -1, -1);

    // R8: bytes beyond the 53rd are not output
    portSel = 2'd1;
    sendCell(32'h0000_0044, 60, 1'b1, 2'd1, "R8", -1, -1);
    idle(8);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule